// File: doc/BRIEF.md
# Disk Controller Host Command Front-End

This block is the register face that a host processor sees on a two-drive disk controller. The host reaches it over a small synchronous byte bus. One address carries commands on write and the status byte on read. The other address reaches an 8-entry parameter/result FIFO. Each command byte is sorted by its upper nibble. A zero nibble means an immediate auxiliary command, whose low four bits each trigger an independent housekeeping action. Any other nibble means a full command, which is handed to the execution engine through a start pulse, together with the latched command code and the selected unit.

The execution engine sits outside this block. It reports back through a `done` pulse, with a qualifier that selects the low or high completion flag, and through a pulse that raises service request. The front-end owns the busy, completion-high, completion-low and service-request flags and the service-request mask, and from them it forms the host interrupt. The host can read the status byte at any time. Bit 0 of that byte shows the live DMA-request line.

Top module: `disk_cmd_frontend`

## Requirements
- R1: A command-address write whose bits 7:4 are zero is auxiliary, and it is accepted even while busy. Its bits act independently: bit 3 clears both completion flags, bit 2 sets the service-request mask, bit 1 rewinds the FIFO, and bit 0 resets the controller.
- R2: The auxiliary reset clears all status flags, the mask and both FIFO pointers, and it pulses `abort` for one cycle. A `done` that arrives afterwards has no effect, because `done` is honoured only while busy.
- R3: A full command written while busy is ignored: no `cmd_start` pulse, and `cmd_code` and `cmd_unit` are unchanged.
- R4: An accepted full command clears both completion flags, sets busy, and latches `cmd_code` = bits 7:4. `cmd_start` pulses in the cycle after the write.
- R5: The unit (`cmd_unit` = bits 1:0, `cmd_drive` = bit 0) is latched for every full command except codes 1 (sense interrupt status), 2 (specify) and 3 (detect error).
- R6: Every command-address write, auxiliary or full, accepted or not, resets both FIFO pointers to zero.
- R7: `irq` is high exactly when completion-high or completion-low is set, or when service request is set and the mask is clear.
- R8: A status read returns bit 7 completion-high, bit 6 completion-low, bit 5 service request, bit 4 busy, bits 3:1 zero, and bit 0 equal to `dma_req`.
- R9: Data-address writes fill FIFO entries 0..7 in order, and data-address reads return them in order. Writes past the eighth entry are dropped, and reads past it return 0.
- R10: Accepting sense interrupt status (code 1) clears service request at once.
- R11: `done` while busy clears busy and the mask. It sets completion-low if `done_err` is high, otherwise completion-high. When the pending code is 1, it also loads `isr_byte` into FIFO entry 0 and pulses `isr_clr`.
- R12: A `srq_set` pulse sets the service-request flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | 1 selects command/status, 0 selects FIFO |
| rd | input | 1 | One-cycle read strobe |
| wr | input | 1 | One-cycle write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| dma_req | input | 1 | Current DMA-request state |
| srq_set | input | 1 | Raise service request |
| done | input | 1 | Command completion pulse |
| done_err | input | 1 | Qualifies done to set completion-low |
| isr_byte | input | 8 | Interrupt-status byte for sense interrupt status |
| irq | output | 1 | Host interrupt |
| cmd_start | output | 1 | Start pulse for an accepted full command |
| cmd_code | output | 4 | Latched command code |
| cmd_unit | output | 2 | Latched unit address |
| cmd_drive | output | 1 | Latched logical drive |
| isr_clr | output | 1 | Pulse to clear the interrupt-status source |
| abort | output | 1 | Pulse on auxiliary reset |

## Verification
The bench hits the FIFO boundary with a ninth write and a ninth read. A design with an off-by-one pointer limit would either overwrite entry 7 or return stale data in place of zero. It issues full commands while busy. A design that did not gate them would restart the engine and overwrite the latched code and unit. It sends auxiliary commands while busy and a `done` after an auxiliary reset. A design that gated auxiliaries would miss the mask, and one that did not tie `done` to busy would set a completion flag after the abort. It also checks that the controller-level codes leave the latched unit alone, and that sense interrupt status delivers the interrupt-status byte through FIFO entry 0.

// File: rtl/disk_cmd_frontend.sv
module disk_cmd_frontend #(
  parameter int DEPTH = 8,
  parameter logic [3:0] OP_SIS  = 4'h1,
  parameter logic [3:0] OP_SPEC = 4'h2,
  parameter logic [3:0] OP_DERR = 4'h3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       dma_req,
  input  logic       srq_set,
  input  logic       done,
  input  logic       done_err,
  input  logic [7:0] isr_byte,
  output logic       irq,
  output logic       cmd_start,
  output logic [3:0] cmd_code,
  output logic [1:0] cmd_unit,
  output logic       cmd_drive,
  output logic       isr_clr,
  output logic       abort
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic ceh, cel, srq, busy, mask;
  logic [PW-1:0] rp, wp;
  logic [7:0] fifo [DEPTH];

  wire       cmd_wr  = wr && addr;
  wire       dat_wr  = wr && !addr;
  wire       dat_rd  = rd && !addr;
  wire [3:0] op      = wdata[7:4];
  wire       is_aux  = (op == 4'h0);
  wire       aux_rst = cmd_wr && is_aux && wdata[0];
  wire       accept  = cmd_wr && !is_aux && !busy;
  wire       ctl_op  = (op == OP_SIS) || (op == OP_SPEC) || (op == OP_DERR);
  wire       fin     = done && busy;

  assign irq   = ceh || cel || (srq && !mask);
  assign rdata = addr ? {ceh, cel, srq, busy, 3'b000, dma_req}
               : ((rp < FULL) ? fifo[rp[AW-1:0]] : 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {ceh, cel, srq, busy, mask} <= '0;
      rp <= '0;
      wp <= '0;
      cmd_code  <= '0;
      cmd_unit  <= '0;
      cmd_drive <= 1'b0;
      cmd_start <= 1'b0;
      isr_clr   <= 1'b0;
      abort     <= 1'b0;
      for (int i = 0; i < DEPTH; i++) fifo[i] <= '0;
    end else begin
      cmd_start <= accept;
      isr_clr   <= fin && (cmd_code == OP_SIS);
      abort     <= aux_rst;
      if (aux_rst) begin
        {ceh, cel, srq, busy, mask} <= '0;
        rp <= '0;
        wp <= '0;
      end else begin
        if (srq_set) srq <= 1'b1;
        if (fin) begin
          busy <= 1'b0;
          mask <= 1'b0;
          if (done_err) cel <= 1'b1;
          else          ceh <= 1'b1;
          if (cmd_code == OP_SIS) fifo[0] <= isr_byte;
        end
        if (cmd_wr && is_aux) begin
          if (wdata[3]) begin ceh <= 1'b0; cel <= 1'b0; end
          if (wdata[2]) mask <= 1'b1;
        end
        if (accept) begin
          ceh <= 1'b0;
          cel <= 1'b0;
          busy <= 1'b1;
          cmd_code <= op;
          if (!ctl_op) begin
            cmd_unit  <= wdata[1:0];
            cmd_drive <= wdata[0];
          end
          if (op == OP_SIS) srq <= 1'b0;
        end
        if (cmd_wr) begin
          rp <= '0;
          wp <= '0;
        end else begin
          if (dat_wr && wp < FULL) begin
            fifo[wp[AW-1:0]] <= wdata;
            wp <= wp + 1'b1;
          end
          if (dat_rd && rp < FULL) rp <= rp + 1'b1;
        end
      end
    end
  end

  a_r4_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && cmd_start && cmd_code == $past(op)));
  a_r3_busy_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !is_aux && busy) |=> (!cmd_start && $stable(cmd_code) && $stable(cmd_unit)));
  a_r2_aux_reset: assert property (@(posedge clk) disable iff (!rst_n)
    aux_rst |=> (!ceh && !cel && !srq && !busy && !mask && abort && rp == 0));
  a_r6_ptr_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (rp == 0 && wp == 0));
  a_r9_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (rp <= FULL) && (wp <= FULL));
  a_r10_sis_drops_srq: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_SIS && !srq_set) |=> !srq);
  a_r11_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !cmd_wr) |=> (!busy && (ceh || cel)));
endmodule

// File: tb/sim_disk_cmd_frontend.sv
module sim_disk_cmd_frontend;
  logic clk = 0, rst_n = 0, addr = 0, rd = 0, wr = 0;
  logic [7:0] wdata = 0, isr_byte = 0;
  logic dma_req = 0, srq_set = 0, done = 0, done_err = 0;
  logic [7:0] rdata;
  logic irq, cmd_start, cmd_drive, isr_clr, abort;
  logic [3:0] cmd_code;
  logic [1:0] cmd_unit;
  int checks = 0, fails = 0;
  bit ended = 0;
  logic seen_start, seen_isr, seen_abort;
  logic [7:0] got;

  always #5 clk = ~clk;

  disk_cmd_frontend u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .dma_req(dma_req), .srq_set(srq_set), .done(done),
    .done_err(done_err), .isr_byte(isr_byte), .irq(irq), .cmd_start(cmd_start),
    .cmd_code(cmd_code), .cmd_unit(cmd_unit), .cmd_drive(cmd_drive),
    .isr_clr(isr_clr), .abort(abort));

  localparam int NV = 29;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0,8'h02,8'h00},
    {2'd1,8'hAA,8'h00},{2'd1,8'hBB,8'h00},{2'd1,8'hCC,8'h00},
    {2'd2,8'h00,8'hAA},{2'd2,8'h00,8'hBB},{2'd2,8'h00,8'hCC},{2'd2,8'h00,8'h00},
    {2'd3,8'h00,8'h00},
    {2'd0,8'h02,8'h00},
    {2'd1,8'h01,8'h00},{2'd1,8'h02,8'h00},{2'd1,8'h03,8'h00},{2'd1,8'h04,8'h00},
    {2'd1,8'h05,8'h00},{2'd1,8'h06,8'h00},{2'd1,8'h07,8'h00},{2'd1,8'h08,8'h00},
    {2'd1,8'h09,8'h00},
    {2'd2,8'h00,8'h01},{2'd2,8'h00,8'h02},{2'd2,8'h00,8'h03},{2'd2,8'h00,8'h04},
    {2'd2,8'h00,8'h05},{2'd2,8'h00,8'h06},{2'd2,8'h00,8'h07},{2'd2,8'h00,8'h08},
    {2'd2,8'h00,8'h00},
    {2'd3,8'h00,8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_op(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wr = 1; wdata = d;
    @(negedge clk); wr = 0;
    seen_start = cmd_start; seen_abort = abort;
  endtask

  task automatic rd_op(input logic a);
    @(negedge clk); addr = a; rd = 1; #1 got = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic pulse_done(input logic err);
    @(negedge clk); done = 1; done_err = err;
    @(negedge clk); done = 0; done_err = 0;
    seen_isr = isr_clr;
  endtask

  task automatic pulse_srq();
    @(negedge clk); srq_set = 1;
    @(negedge clk); srq_set = 0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_op(1); chk("R8 reset status", got, 8'h00);
    chk("R7 reset irq", {7'b0, irq}, 8'h00);
    rd_op(0); chk("R9 reset fifo", got, 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        2'd0: wr_op(1, VEC[i][15:8]);
        2'd1: wr_op(0, VEC[i][15:8]);
        2'd2: begin rd_op(0); chk("R9 fifo read", got, VEC[i][7:0]); end
        default: begin rd_op(1); chk("R8 status", got, VEC[i][7:0]); end
      endcase
    end

    wr_op(1, 8'h53);
    chk("R4 start pulse", {7'b0, seen_start}, 8'h01);
    chk("R4 code", {4'b0, cmd_code}, 8'h05);
    chk("R5 unit", {5'b0, cmd_drive, cmd_unit}, 8'h07);
    rd_op(1); chk("R4 busy status", got, 8'h10);

    wr_op(1, 8'h71);
    chk("R3 no start while busy", {7'b0, seen_start}, 8'h00);
    chk("R3 code held", {4'b0, cmd_code}, 8'h05);
    chk("R3 unit held", {6'b0, cmd_unit}, 8'h03);

    wr_op(1, 8'h04);
    pulse_srq();
    chk("R1 aux mask while busy irq", {7'b0, irq}, 8'h00);
    rd_op(1); chk("R12 srq status", got, 8'h30);

    pulse_done(0);
    rd_op(1); chk("R11 done status", got, 8'hA0);
    chk("R11 mask cleared irq", {7'b0, irq}, 8'h01);
    wr_op(1, 8'h08);
    rd_op(1); chk("R1 aux clear completion", got, 8'h20);
    chk("R7 srq unmasked irq", {7'b0, irq}, 8'h01);
    wr_op(1, 8'h04);
    chk("R7 srq masked irq", {7'b0, irq}, 8'h00);

    wr_op(1, 8'h12);
    rd_op(1); chk("R10 sis clears srq", got, 8'h10);
    chk("R5 unit kept on sis", {5'b0, cmd_drive, cmd_unit}, 8'h07);
    isr_byte = 8'h5A;
    pulse_done(0);
    chk("R11 isr_clr pulse", {7'b0, seen_isr}, 8'h01);
    rd_op(0); chk("R11 isr byte in fifo0", got, 8'h5A);
    dma_req = 1;
    rd_op(1); chk("R8 dma bit", got, 8'h81);
    dma_req = 0;

    wr_op(1, 8'h60);
    chk("R5 unit zero", {5'b0, cmd_drive, cmd_unit}, 8'h00);
    rd_op(1); chk("R4 completion cleared", got, 8'h10);
    pulse_done(1);
    rd_op(1); chk("R11 done_err sets low", got, 8'h40);
    chk("R7 low irq", {7'b0, irq}, 8'h01);

    wr_op(1, 8'h70);
    pulse_srq();
    wr_op(1, 8'h01);
    chk("R2 abort pulse", {7'b0, seen_abort}, 8'h01);
    rd_op(1); chk("R2 status cleared", got, 8'h00);
    chk("R2 irq low", {7'b0, irq}, 8'h00);
    pulse_done(0);
    rd_op(1); chk("R2 late done ignored", got, 8'h00);

    wr_op(1, 8'h02);
    wr_op(0, 8'h11); wr_op(0, 8'h22);
    rd_op(0); chk("R6 first read", got, 8'h11);
    wr_op(1, 8'h80);
    rd_op(0); chk("R6 rewind on full cmd", got, 8'h11);
    pulse_done(0);
    rd_op(0);
    wr_op(1, 8'h00);
    rd_op(0); chk("R6 rewind on empty aux", got, 8'h11);

    finish_run();
  end
endmodule